// File: doc/BRIEF.md
# Configurable Processor Data Bus Interface

This block sits between a processor core's internal read and write data paths and the external memory data connections. A static mode input selects one of two wirings. In shared mode a single bidirectional bus carries both directions. In split mode a dedicated input bus carries reads and a dedicated output bus carries writes. The bidirectional bus is modelled as three plain ports: the value sampled from the pad, the value to drive, and a drive enable.

The core presents the direction of the next bus cycle and its write data before a rising clock edge. The block registers them on that edge, so the write data and an active-low write-cycle flag are stable for the whole cycle, including across its falling edge. Read data is captured on the falling edge, one byte lane at a time, under a per-lane latch mask. A data-bus enable can block all write output. An external active-low drive permit can block the bidirectional driver, which lets a shared-bus arbiter take the bus.

Top module: `cpu_dbus_if`

## Requirements
- R1: While rst_ni is low, rdata_o is zero, bidir_oe_o is 0, bidir_out_o is zero, uni_out_o is zero and wr_cycle_n_o is 1, whatever rw_i is.
- R2: With split_mode_i = 0 (shared mode), read data is captured from bidir_in_i, uni_in_i has no effect on rdata_o, and uni_out_o is zero in every cycle.
- R3: With split_mode_i = 1 (split mode), read data is captured from uni_in_i and bidir_in_i has no effect on rdata_o. In a write cycle with dbus_en_i = 1, uni_out_o carries the registered write data.
- R4: In a write cycle with dbus_en_i = 1 and wdrive_n_i = 0, bidir_oe_o is 1 and bidir_out_o equals the registered write data, in either mode. In a read cycle bidir_oe_o is 0.
- R5: With dbus_en_i = 0, bidir_oe_o is 0, and both bidir_out_o and uni_out_o are zero.
- R6: With wdrive_n_i = 1 in a write cycle, bidir_oe_o is 0 and bidir_out_o is zero. uni_out_o is not affected by wdrive_n_i.
- R7: A rising edge that samples rw_i = 1 starts a write cycle. wr_cycle_n_o is 0 for that whole cycle. After a rising edge that samples rw_i = 0 it is 1.
- R8: On the falling edge of a read cycle, byte lane i (rdata_o bits 8i+7 to 8i at the default lane width) is loaded from the selected input bus only if lane_latch_i bit i is 1. No lane is loaded in a write cycle.
- R9: A byte lane whose lane_latch_i bit is 0 keeps its previously captured value.
- R10: The write data on bidir_out_o and uni_out_o is taken from wdata_i at the rising edge that starts the cycle. It is held unchanged through that cycle's falling edge, even if wdata_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; rising edge starts a cycle, falling edge captures reads |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rw_i | input | 1 | Direction of the next cycle: 1 write, 0 read |
| split_mode_i | input | 1 | Static mode: 0 shared bidirectional bus, 1 split buses |
| dbus_en_i | input | 1 | Data-bus enable; 0 blocks all write output |
| wdrive_n_i | input | 1 | Active-low permit for driving the bidirectional bus on writes |
| lane_latch_i | input | LANES (4) | Per-byte-lane read latch enables |
| wdata_i | input | DATA_W (32) | Write data from the core for the next cycle |
| bidir_in_i | input | DATA_W (32) | Value seen on the bidirectional bus |
| uni_in_i | input | DATA_W (32) | Dedicated input bus |
| rdata_o | output | DATA_W (32) | Captured read data to the core |
| bidir_out_o | output | DATA_W (32) | Value driven onto the bidirectional bus |
| bidir_oe_o | output | 1 | Drive enable for the bidirectional bus |
| uni_out_o | output | DATA_W (32) | Dedicated output bus |
| wr_cycle_n_o | output | 1 | Active-low write-cycle flag for arbitration |

## Verification
The bench builds the block with its default four lanes of eight bits. At that size every lane mask the tests need can be applied: all lanes, none, alternating lanes and a single top lane. Each lane can also be given a distinct byte, so a wrong lane selection or a wrong source bus shows up as a visible byte mismatch. Both modes are run with each gating input (dbus_en_i, wdrive_n_i) toggled in write cycles. Read cycles are run with the unselected input bus changing, to show that it has no effect.

// File: rtl/cpu_dbus_pkg.sv
package cpu_dbus_pkg;
  typedef enum logic {
    BUS_SHARED = 1'b0,
    BUS_SPLIT  = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/cpu_dbus_wr.sv
module cpu_dbus_wr
  import cpu_dbus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  bus_mode_e         mode_i,
  input  logic              dbus_en_i,
  input  logic              wdrive_n_i,
  output logic              rd_cycle_o,
  output logic              wr_cycle_n_o,
  output logic [DATA_W-1:0] bidir_out_o,
  output logic              bidir_oe_o,
  output logic [DATA_W-1:0] uni_out_o
);
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  // cycle direction and data are fixed at the rising edge for the whole cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      wr_q <= rw_i;
      if (rw_i) wdata_q <= wdata_i;
    end
  end

  logic drive_bidir;
  logic drive_uni;

  always_comb begin
    drive_bidir  = wr_q && dbus_en_i && !wdrive_n_i;
    drive_uni    = wr_q && dbus_en_i && (mode_i == BUS_SPLIT);
    bidir_oe_o   = drive_bidir;
    bidir_out_o  = drive_bidir ? wdata_q : '0;
    uni_out_o    = drive_uni ? wdata_q : '0;
    wr_cycle_n_o = !wr_q;
    rd_cycle_o   = rst_ni && !wr_q;
  end
endmodule

// File: rtl/cpu_dbus_rd_lane.sv
module cpu_dbus_rd_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [LANE_W-1:0] src_i,
  output logic [LANE_W-1:0] q_o
);
  // read lanes are captured on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (capture_i) q_o <= src_i;
  end
endmodule

// File: rtl/cpu_dbus_if.sv
module cpu_dbus_if
  import cpu_dbus_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rw_i,
  input  logic              split_mode_i,
  input  logic              dbus_en_i,
  input  logic              wdrive_n_i,
  input  logic [LANES-1:0]  lane_latch_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bidir_in_i,
  input  logic [DATA_W-1:0] uni_in_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] bidir_out_o,
  output logic              bidir_oe_o,
  output logic [DATA_W-1:0] uni_out_o,
  output logic              wr_cycle_n_o
);
  bus_mode_e         mode;
  logic              rd_cycle;
  logic [DATA_W-1:0] rd_src;

  assign mode   = bus_mode_e'(split_mode_i);
  assign rd_src = (mode == BUS_SPLIT) ? uni_in_i : bidir_in_i;

  cpu_dbus_wr #(.DATA_W(DATA_W)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rw_i         (rw_i),
    .wdata_i      (wdata_i),
    .mode_i       (mode),
    .dbus_en_i    (dbus_en_i),
    .wdrive_n_i   (wdrive_n_i),
    .rd_cycle_o   (rd_cycle),
    .wr_cycle_n_o (wr_cycle_n_o),
    .bidir_out_o  (bidir_out_o),
    .bidir_oe_o   (bidir_oe_o),
    .uni_out_o    (uni_out_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cpu_dbus_rd_lane #(.LANE_W(LANE_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (rd_cycle && lane_latch_i[g]),
      .src_i     (rd_src[g*LANE_W +: LANE_W]),
      .q_o       (rdata_o[g*LANE_W +: LANE_W])
    );

    // R9
    lane_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !lane_latch_i[g] |=> $stable(rdata_o[g*LANE_W +: LANE_W]));
  end

  // R2
  uni_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !split_mode_i |-> (uni_out_o == '0));

  // R4
  read_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cycle_n_o |-> !bidir_oe_o);

  // R5
  dbus_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbus_en_i |-> (!bidir_oe_o && uni_out_o == '0 && bidir_out_o == '0));

  // R7
  wr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_i |=> !wr_cycle_n_o);
endmodule

// File: tb/cpu_dbus_if_tb.sv
module cpu_dbus_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rw_i = 1'b0;
  logic          split_mode_i = 1'b0;
  logic          dbus_en_i = 1'b1;
  logic          wdrive_n_i = 1'b0;
  logic [LANES-1:0] lane_latch_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] bidir_in_i = '0;
  logic [DW-1:0] uni_in_i = '0;
  logic [DW-1:0] rdata_o, bidir_out_o, uni_out_o;
  logic          bidir_oe_o, wr_cycle_n_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string         tag;
    logic [DW-1:0] rd;
    logic [DW-1:0] bout;
    logic          oe;
    logic [DW-1:0] uout;
    logic          wr_n;
  } exp_t;

  exp_t          sb_q[$];
  logic [DW-1:0] model_rd = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cpu_dbus_if #(.LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk_i, .rst_ni, .rw_i, .split_mode_i, .dbus_en_i, .wdrive_n_i,
    .lane_latch_i, .wdata_i, .bidir_in_i, .uni_in_i,
    .rdata_o, .bidir_out_o, .bidir_oe_o, .uni_out_o, .wr_cycle_n_o
  );

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: applies one bus cycle and pushes its expected outcome
  task automatic drive(input logic rw, input logic [DW-1:0] wd, input logic split,
                       input logic den, input logic wdn, input logic [LANES-1:0] lat,
                       input logic [DW-1:0] bin, input logic [DW-1:0] uin,
                       input string tag);
    exp_t e;
    @(negedge clk_i); #3;
    rw_i = rw; wdata_i = wd; split_mode_i = split; dbus_en_i = den;
    wdrive_n_i = wdn; lane_latch_i = lat; bidir_in_i = bin; uni_in_i = uin;
    if (!rw)
      for (int i = 0; i < LANES; i++)
        if (lat[i]) model_rd[i*LANE_W +: LANE_W] = split ? uin[i*LANE_W +: LANE_W]
                                                         : bin[i*LANE_W +: LANE_W];
    e.tag  = tag;
    e.rd   = model_rd;
    e.oe   = rw && den && !wdn;
    e.bout = e.oe ? wd : '0;
    e.uout = (rw && den && split) ? wd : '0;
    e.wr_n = !rw;
    sb_q.push_back(e);
  endtask

  // monitor: compares after the falling edge that closes the cycle's capture
  initial begin
    forever begin
      @(negedge clk_i); #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "rdata_o",      rdata_o,      e.rd);
        chk(e.tag, "bidir_out_o",  bidir_out_o,  e.bout);
        chk(e.tag, "bidir_oe_o",   DW'(bidir_oe_o),   DW'(e.oe));
        chk(e.tag, "uni_out_o",    uni_out_o,    e.uout);
        chk(e.tag, "wr_cycle_n_o", DW'(wr_cycle_n_o), DW'(e.wr_n));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, also with a write requested while in reset
    #12;
    chk("R1", "rdata_o", rdata_o, '0);
    chk("R1", "bidir_oe_o", DW'(bidir_oe_o), '0);
    chk("R1", "uni_out_o", uni_out_o, '0);
    rw_i = 1'b1; wdata_i = 32'h1234_5678; split_mode_i = 1'b1;
    @(posedge clk_i); #2;
    chk("R1", "wr_cycle_n_o", DW'(wr_cycle_n_o), DW'(1'b1));
    chk("R1", "bidir_out_o", bidir_out_o, '0);
    chk("R1", "uni_out_o in reset", uni_out_o, '0);
    @(negedge clk_i); #3;
    rw_i = 1'b0;
    rst_ni = 1'b1;

    //     rw   wdata         sp   den  wdn  lat      bidir_in      uni_in
    drive(1'b0, 32'h0,        1'b0,1'b1,1'b0,4'b1111, 32'hA1B2C3D4, 32'h5555_5555, "R2 shared read");
    drive(1'b1, 32'hDEADBEEF, 1'b0,1'b1,1'b0,4'b1111, 32'h1111_1111,32'h2222_2222, "R4 R8 shared write");
    drive(1'b0, 32'h0,        1'b0,1'b1,1'b0,4'b0101, 32'h9988_7766,32'h3333_3333, "R8 R9 alt lanes");
    drive(1'b0, 32'h0,        1'b1,1'b1,1'b0,4'b1111, 32'h1234_5678,32'hCAFE_F00D, "R3 split read");
    drive(1'b1, 32'h0BAD_F00D,1'b1,1'b1,1'b0,4'b1111, 32'h4444_4444,32'h6666_6666, "R3 R4 split write");
    drive(1'b1, 32'h1357_9BDF,1'b1,1'b1,1'b1,4'b1111, 32'h0,        32'h0,         "R6 split no drive");
    drive(1'b1, 32'h2468_ACE0,1'b0,1'b1,1'b1,4'b0000, 32'h0,        32'h0,         "R6 shared no drive");
    drive(1'b1, 32'h7777_8888,1'b1,1'b0,1'b0,4'b1111, 32'h0,        32'h0,         "R5 split bus off");
    drive(1'b1, 32'h9999_AAAA,1'b0,1'b0,1'b0,4'b1111, 32'h0,        32'h0,         "R5 shared bus off");
    drive(1'b1, 32'hF0E1_D2C3,1'b0,1'b1,1'b0,4'b1111, 32'h0,        32'h0,         "R10 R7 back to back write");
    drive(1'b1, 32'h0F1E_2D3C,1'b1,1'b1,1'b0,4'b1111, 32'h0,        32'h0,         "R10 R7 second write");
    drive(1'b0, 32'hFFFF_FFFF,1'b1,1'b1,1'b0,4'b1000, 32'hEEEE_EEEE,32'h77AB_CDEF, "R8 top lane");
    drive(1'b0, 32'h0,        1'b1,1'b1,1'b0,4'b0000, 32'hBBBB_BBBB,32'hCCCC_CCCC, "R9 no lanes");
    drive(1'b0, 32'h0,        1'b0,1'b1,1'b0,4'b1111, 32'h0102_0304,32'hFEDC_BA98, "R2 uni ignored");
    drive(1'b0, 32'h0,        1'b1,1'b0,1'b0,4'b0011, 32'h5A5A_5A5A,32'hA5A5_C3C3, "R3 R5 read with bus off");
    drive(1'b1, 32'h8000_0001,1'b0,1'b1,1'b0,4'b1111, 32'h0,        32'h0,         "R7 final write");
    drive(1'b0, 32'h0,        1'b0,1'b1,1'b0,4'b0000, 32'h0,        32'h0,         "R7 R4 read after write");

    // R10: change wdata_i mid-cycle; outputs must hold the registered value
    @(negedge clk_i); #3;
    rw_i = 1'b1; wdata_i = 32'h3C3C_3C3C; split_mode_i = 1'b1; dbus_en_i = 1'b1; wdrive_n_i = 1'b0;
    @(posedge clk_i); #1;
    rw_i = 1'b0; wdata_i = 32'hC3C3_C3C3;
    @(negedge clk_i); #2;
    chk("R10", "bidir_out_o held", bidir_out_o, 32'h3C3C_3C3C);
    chk("R10", "uni_out_o held", uni_out_o, 32'h3C3C_3C3C);

    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule